// File: doc/BRIEF.md
# Game Cartridge Bus Responder

This block sits on the cartridge side of an 8-bit console's CPU bus. It runs from a fast local clock and watches the slow bus phase clock, the read/write line, fifteen address lines and an active-low select line. The console derives that select line from the top address bit, which does not reach the cartridge edge. The block serves reads from an internal program store mapped into the upper half of the address space. Writes into that upper half are stored, so the region behaves as RAM. A separate work-RAM window sits in the lower half, in the span where the two highest available address lines are both high.

The select line settles tens of nanoseconds after the phase clock rises, so the block does not trust it straight away. It waits a configurable number of fast clock cycles after the synchronized phase rise, and only then samples the select line and the address to decide the region. That decision is a delayed copy of the phase. A read response is launched on the rise of this delayed copy. Write address and data are committed on the fall of the undelayed phase. The data-bus drive enable is the AND of the phase and its delayed copy, and it is raised only for reads to a region the block owns.

Top module: `cart_bus_responder`

## Requirements
- R1: While reset is held and after it is released with an idle bus, `bus_drive` is 0 and `bus_dout` is 0.
- R2: A read in which `bus_romsel_n` is low at the delayed sample returns the program byte at index `bus_addr[PRG_AW-1:0]`, with `bus_drive` high. Before any write, the byte at index i is `(i*5 + (i>>8)) mod 256`.
- R3: The region is decided from `bus_romsel_n` as sampled DELAY_CYC fast cycles after the synchronized phase rise. A select that settles within DELAY_CYC cycles of the phase pin rising is classified as upper. A select that settles later is treated as a lower-half access.
- R4: An access with `bus_romsel_n` high at the delayed sample and `bus_addr[14:13]` = 2'b11 uses work RAM at index `bus_addr[WRAM_AW-1:0]`. Before any write, the byte at index i is `(i mod 256) XOR 8'h5A`.
- R5: A lower-half access outside the work-RAM window is ignored. A read there leaves `bus_drive` low. A write there changes neither store.
- R6: A write (`bus_rw` = 0) classified as upper stores `bus_din` into the program store at the address held when the phase falls, and a later read returns the new byte.
- R7: A write to the work-RAM window stores `bus_din`, and a later read returns it.
- R8: `bus_drive` is high only during a read to an owned region. It is never high during a write. It is low within three fast clock edges of the phase pin falling.
- R9: Once a read response is launched, `bus_dout` stays constant while `bus_drive` remains high.
- R10: A phase pulse that falls before the delayed sample is taken produces no access. No data is driven and no store is written.
- R11: Address bits above the store width are ignored. Upper-half address 0x0800 reads the same cell as 0x0000 when PRG_AW is 11, and window address 0x6400 reads the same cell as 0x6000 when WRAM_AW is 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_m2 | input | 1 | Bus phase clock, high during the data phase |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 15 | CPU address bits 14..0 |
| bus_romsel_n | input | 1 | Active-low upper-half select, settles late |
| bus_din | input | 8 | Data bus value seen by the cartridge |
| bus_dout | output | 8 | Value to place on the data bus |
| bus_drive | output | 1 | Data bus output enable |

## Verification
The bench builds the block with DELAY_CYC = 4, PRG_AW = 11 and WRAM_AW = 10. The short delay lets the bench sweep the select arrival from zero to one cycle past the limit within a bus cycle of ten fast clocks, and it shows the late select being classified as a lower-half access. The small store widths bring address aliasing within reach of single accesses. A phase pulse of three cycles is shorter than the delay, which exercises the aborted access.

// File: rtl/cart_pkg.sv
package cart_pkg;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_PRG  = 2'd1,
      RGN_WRAM = 2'd2
   } rgn_e;

   function automatic logic [7:0] prg_seed(input int unsigned idx);
      return 8'((idx * 5) + (idx >> 8));
   endfunction

   function automatic logic [7:0] wram_seed(input int unsigned idx);
      return 8'(idx) ^ 8'h5A;
   endfunction

endpackage

// File: rtl/cart_sync.sv
module cart_sync #(
   parameter int           W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("cart_sync: W must be positive");
   end

   logic [W-1:0] stage1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1 <= RST_VAL;
         q      <= RST_VAL;
      end else begin
         stage1 <= d;
         q      <= stage1;
      end
   end
endmodule

// File: rtl/cart_phase.sv
module cart_phase #(
   parameter int DELAY_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic m2_s,
   output logic strobe,
   output logic fall,
   output logic acc_en
);
   localparam int CNT_W = (DELAY_CYC < 1) ? 1 : $clog2(DELAY_CYC + 1);

   if (DELAY_CYC < 0 || DELAY_CYC > 255) begin : g_bad_delay
      $error("cart_phase: DELAY_CYC out of range");
   end

   logic m2_prev;
   logic dly_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) m2_prev <= 1'b0;
      else        m2_prev <= m2_s;
   end

   assign fall   = m2_prev & ~m2_s;
   assign acc_en = m2_s & dly_q;

   if (DELAY_CYC == 0) begin : g_nodelay
      assign strobe = m2_s & ~m2_prev;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     dly_q <= 1'b0;
         else if (!m2_s) dly_q <= 1'b0;
         else if (strobe) dly_q <= 1'b1;
      end
   end else begin : g_counted
      logic [CNT_W-1:0] cnt_q;
      assign strobe = m2_s & ~dly_q & (cnt_q == CNT_W'(DELAY_CYC));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
            dly_q <= 1'b0;
         end else if (!m2_s) begin
            cnt_q <= '0;
            dly_q <= 1'b0;
         end else if (strobe) begin
            dly_q <= 1'b1;
         end else if (!dly_q) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cart_decode.sv
module cart_decode
   import cart_pkg::*;
(
   input  logic       romsel_n_s,
   input  logic [1:0] addr_hi,
   output rgn_e       rgn
);
   always_comb begin
      if (!romsel_n_s)            rgn = RGN_PRG;
      else if (addr_hi == 2'b11)  rgn = RGN_WRAM;
      else                        rgn = RGN_NONE;
   end
endmodule

// File: rtl/cart_bus_responder.sv
module cart_bus_responder
   import cart_pkg::*;
#(
   parameter int DELAY_CYC = 4,
   parameter int PRG_AW    = 11,
   parameter int WRAM_AW   = 10
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_m2,
   input  logic        bus_rw,
   input  logic [14:0] bus_addr,
   input  logic        bus_romsel_n,
   input  logic [7:0]  bus_din,
   output logic [7:0]  bus_dout,
   output logic        bus_drive
);
   localparam int PRG_DEPTH  = 1 << PRG_AW;
   localparam int WRAM_DEPTH = 1 << WRAM_AW;
   localparam int SYNC_W     = 1 + 1 + 1 + 15 + 8;
   localparam int HC_W       = (DELAY_CYC < 1) ? 1 : $clog2(DELAY_CYC + 1);

   if (PRG_AW < 1 || PRG_AW > 15) begin : g_bad_prg
      $error("cart_bus_responder: PRG_AW must be 1..15");
   end
   if (WRAM_AW < 1 || WRAM_AW > 13) begin : g_bad_wram
      $error("cart_bus_responder: WRAM_AW must be 1..13");
   end

   logic        m2_s, rw_s, romsel_n_s;
   logic [14:0] addr_s;
   logic [7:0]  din_s;

   cart_sync #(
      .W      (SYNC_W),
      .RST_VAL({1'b0, 1'b1, 1'b1, 15'd0, 8'd0})
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({bus_m2, bus_rw, bus_romsel_n, bus_addr, bus_din}),
      .q    ({m2_s, rw_s, romsel_n_s, addr_s, din_s})
   );

   logic strobe, fall, acc_en;

   cart_phase #(.DELAY_CYC(DELAY_CYC)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .m2_s  (m2_s),
      .strobe(strobe),
      .fall  (fall),
      .acc_en(acc_en)
   );

   rgn_e rgn_now;

   cart_decode u_decode (
      .romsel_n_s(romsel_n_s),
      .addr_hi   (addr_s[14:13]),
      .rgn       (rgn_now)
   );

   logic [7:0] prg_mem  [PRG_DEPTH];
   logic [7:0] wram_mem [WRAM_DEPTH];

   initial begin
      for (int i = 0; i < PRG_DEPTH; i++)  prg_mem[i]  = prg_seed(i);
      for (int i = 0; i < WRAM_DEPTH; i++) wram_mem[i] = wram_seed(i);
   end

   logic       addr_unused;
   assign addr_unused = ^addr_s;

   logic [7:0] rd_byte;
   assign rd_byte = (rgn_now == RGN_PRG) ? prg_mem[addr_s[PRG_AW-1:0]]
                                         : wram_mem[addr_s[WRAM_AW-1:0]];

   rgn_e cur_rgn;
   logic cur_rd;
   logic reg_vld;
   logic drive_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_rgn  <= RGN_NONE;
         cur_rd   <= 1'b1;
         reg_vld  <= 1'b0;
         drive_q  <= 1'b0;
         bus_dout <= 8'h00;
      end else if (strobe) begin
         cur_rgn <= rgn_now;
         cur_rd  <= rw_s;
         reg_vld <= 1'b1;
         if (rw_s && rgn_now != RGN_NONE) begin
            drive_q  <= 1'b1;
            bus_dout <= rd_byte;
         end
      end else if (fall) begin
         cur_rgn <= RGN_NONE;
         reg_vld <= 1'b0;
         drive_q <= 1'b0;
      end
   end

   logic wr_commit;
   assign wr_commit = fall & reg_vld & ~cur_rd;

   always_ff @(posedge clk) begin
      if (wr_commit && cur_rgn == RGN_PRG)  prg_mem[addr_s[PRG_AW-1:0]]   <= din_s;
      if (wr_commit && cur_rgn == RGN_WRAM) wram_mem[addr_s[WRAM_AW-1:0]] <= din_s;
   end

   assign bus_drive = drive_q & acc_en;

   logic [HC_W-1:0] hcnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             hcnt_q <= '0;
      else if (!m2_s)                         hcnt_q <= '0;
      else if (hcnt_q != HC_W'(DELAY_CYC))    hcnt_q <= hcnt_q + 1'b1;
   end

   a_r3_late_decision: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_vld) |-> (hcnt_q >= HC_W'(DELAY_CYC)));

   a_r8_drive_only_read: assert property (@(posedge clk) disable iff (!rst_n)
      bus_drive |-> (cur_rd && cur_rgn != RGN_NONE));

   a_r9_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_drive && $past(bus_drive)) |-> $stable(bus_dout));

   a_r4_window_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_drive && cur_rgn == RGN_WRAM) |-> (addr_s[14:13] == 2'b11));

endmodule

// File: tb/cart_bus_responder_bench.sv
module cart_bus_responder_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DLY        = 4;
   localparam int PAW        = 11;
   localparam int WAW        = 10;
   localparam int HI_LONG    = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_m2 = 1'b0;
   logic        bus_rw = 1'b1;
   logic [14:0] bus_addr = '0;
   logic        bus_romsel_n = 1'b1;
   logic [7:0]  bus_din = '0;
   logic [7:0]  bus_dout;
   logic        bus_drive;

   always #(CLK_PERIOD/2) clk = ~clk;

   cart_bus_responder #(.DELAY_CYC(DLY), .PRG_AW(PAW), .WRAM_AW(WAW)) u_cart_bus_responder (
      .clk(clk), .rst_n(rst_n), .bus_m2(bus_m2), .bus_rw(bus_rw),
      .bus_addr(bus_addr), .bus_romsel_n(bus_romsel_n), .bus_din(bus_din),
      .bus_dout(bus_dout), .bus_drive(bus_drive));

   typedef struct {
      bit         drive;
      bit         chk_data;
      logic [7:0] data;
      string      tag;
   } exp_t;

   exp_t q[$];
   event chk_ev;
   int   checks = 0;
   int   errors = 0;
   bit   done = 0;

   logic [7:0] prg_m  [1 << PAW];
   logic [7:0] wram_m [1 << WAW];

   initial begin
      for (int i = 0; i < (1 << PAW); i++) prg_m[i]  = 8'((i * 5) + (i >> 8));
      for (int i = 0; i < (1 << WAW); i++) wram_m[i] = 8'(i) ^ 8'h5A;
   end

   // monitor: pops expectations and compares against the ports
   initial begin
      forever begin
         @(chk_ev);
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (bus_drive !== e.drive || (e.chk_data && bus_dout !== e.data)) begin
               errors++;
               $display("FAIL %s: drive=%0b dout=%02h expected drive=%0b dout=%02h",
                        e.tag, bus_drive, bus_dout, e.drive, e.data);
            end
         end
      end
   end

   task automatic expect_now(input bit drv, input bit cd, input logic [7:0] d, input string tag);
      exp_t e;
      e.drive = drv; e.chk_data = cd; e.data = d; e.tag = tag;
      q.push_back(e);
      -> chk_ev;
      #1;
   endtask

   // one bus cycle; hi = phase-high length in fast cycles, lag = select arrival
   task automatic bus_op(input logic [14:0] a, input bit wr, input logic [7:0] wd,
                         input bit upper, input int lag, input int hi, input string tag);
      bit taken, as_upper;
      int rgn;
      logic [7:0] exp_b;
      taken    = (hi >= 8);
      as_upper = upper && (lag <= DLY);
      if (as_upper)               rgn = 1;
      else if (a[14:13] == 2'b11) rgn = 2;
      else                        rgn = 0;
      exp_b = (rgn == 1) ? prg_m[a[PAW-1:0]] : wram_m[a[WAW-1:0]];
      @(negedge clk);
      bus_addr = a; bus_rw = ~wr; bus_din = wd; bus_m2 = 1'b1; bus_romsel_n = 1'b1;
      for (int i = 0; i < hi; i++) begin
         if (upper && i == lag) bus_romsel_n = 1'b0;
         if (taken && i == hi - 2)
            expect_now(!wr && rgn != 0, !wr && rgn != 0, exp_b, tag);
         if (taken && i == hi - 1)
            expect_now(!wr && rgn != 0, !wr && rgn != 0, exp_b, "R9 hold");
         @(negedge clk);
      end
      bus_m2 = 1'b0; bus_romsel_n = 1'b1;
      repeat (3) @(negedge clk);
      expect_now(1'b0, 1'b0, 8'h00, "R8 release");
      repeat (2) @(negedge clk);
      bus_rw = 1'b1;
      if (taken && wr) begin
         if (rgn == 1) prg_m[a[PAW-1:0]]  = wd;
         if (rgn == 2) wram_m[a[WAW-1:0]] = wd;
      end
   endtask

   task automatic finish_sim();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         finish_sim();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      expect_now(1'b0, 1'b1, 8'h00, "R1 in reset");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      expect_now(1'b0, 1'b1, 8'h00, "R1 after reset");

      // R2 upper reads
      bus_op(15'h0000, 0, 0, 1, 2, HI_LONG, "R2 read 0000");
      bus_op(15'h0123, 0, 0, 1, 2, HI_LONG, "R2 read 0123");
      bus_op(15'h07FF, 0, 0, 1, 1, HI_LONG, "R2 read 07FF");
      bus_op(15'h7FFF, 0, 0, 1, 3, HI_LONG, "R2 read 7FFF");
      // R11 aliasing
      bus_op(15'h0800, 0, 0, 1, 2, HI_LONG, "R11 alias 0800");
      bus_op(15'h6400, 0, 0, 0, 0, HI_LONG, "R11 alias 6400");
      // R3 select arrival sweep
      for (int l = 0; l <= DLY; l++) begin
         bus_op(15'h0345, 0, 0, 1, l, HI_LONG, "R3 sweep upper");
         bus_op(15'h6010, 0, 0, 0, l, HI_LONG, "R3 sweep window");
      end
      bus_op(15'h0100, 0, 0, 1, DLY + 1, HI_LONG, "R3 late select ignored");
      bus_op(15'h6005, 0, 0, 1, DLY + 1, HI_LONG, "R3 late select as window");
      // R4 window reads
      bus_op(15'h6000, 0, 0, 0, 0, HI_LONG, "R4 read 6000");
      bus_op(15'h7FFF, 0, 0, 0, 0, HI_LONG, "R4 read 7FFF");
      bus_op(15'h6155, 0, 0, 0, 0, HI_LONG, "R4 read 6155");
      // R5 unowned lower space
      bus_op(15'h2000, 0, 0, 0, 0, HI_LONG, "R5 read 2000 no drive");
      bus_op(15'h4005, 1, 8'hEE, 0, 0, HI_LONG, "R5 write 4005");
      bus_op(15'h6005, 0, 0, 0, 0, HI_LONG, "R5 window cell untouched");
      bus_op(15'h0005, 0, 0, 1, 2, HI_LONG, "R5 upper cell untouched");
      // R6 upper writes
      bus_op(15'h0155, 1, 8'hA7, 1, 2, HI_LONG, "R6 write 0155");
      bus_op(15'h0155, 0, 0, 1, 2, HI_LONG, "R6 readback 0155");
      bus_op(15'h7FF0, 1, 8'h3E, 1, DLY, HI_LONG, "R6 write 7FF0");
      bus_op(15'h07F0, 0, 0, 1, 0, HI_LONG, "R6 readback 07F0");
      // R7 window writes
      bus_op(15'h6123, 1, 8'h3C, 0, 0, HI_LONG, "R7 write 6123");
      bus_op(15'h6123, 0, 0, 0, 0, HI_LONG, "R7 readback 6123");
      // R10 short pulses
      bus_op(15'h0200, 1, 8'h11, 1, 0, 3, "R10 short write");
      bus_op(15'h0200, 0, 0, 1, 0, 3, "R10 short read");
      bus_op(15'h0200, 0, 0, 1, 1, HI_LONG, "R10 cell unchanged");
      bus_op(15'h6200, 1, 8'h22, 0, 0, 3, "R10 short window write");
      bus_op(15'h6200, 0, 0, 0, 0, HI_LONG, "R10 window unchanged");

      done = 1;
      finish_sim();
   end
endmodule